// File: doc/BRIEF.md
# Conversion Result FIFO With Stage-Count Interrupt

This block queues the results of an analog-to-digital converter until software collects them. For each finished conversion it stores the 12-bit result, a code for what started the conversion and the channel number. It returns them in arrival order through a 32-bit read word. One parameter sets the depth: 16 stages suit the channel-scanning path and 4 stages suit the urgent single-channel path.

The read port receives the access size and the byte lane of each bus read. Only an access that covers the most significant byte advances the queue, so software can read the low parts of the word first. A fill-level threshold raises a sticky request flag. An enable then gates that flag onto the interrupt line. A write into a full queue is dropped and recorded in a sticky overflow flag. A clear command empties the queue.

Top module: `adc_result_fifo`

## Requirements
- R1: After synchronous reset, `empty` is 1 and `full`, `ovf_flag`, `irq_flag` and `irq` are 0.
- R2: Entries are read in write order. The read word holds the result in bits 31:20, the start-factor code in bits 9:8 and the channel in bits 4:0, and every other bit except bit 12 is 0.
- R3: `full` is 1 when all DEPTH stages hold data. A write while full, without a pop in the same cycle, is dropped, leaves the stored entries unchanged and sets `ovf_flag`.
- R4: A `clr_fifo` pulse empties the queue, so `empty` reads 1 in the following cycle.
- R5: A read pops one entry only when `rd_size`=2 (word), or `rd_size`=1 (half-word) with `rd_lane[1]`=1, or `rd_size`=0 (byte) with `rd_lane`=3. Any other size or lane leaves the queue unchanged.
- R6: Bit 12 of `rd_data` is 1, and all other bits are 0, while the queue is empty, and 0 otherwise. A read of an empty queue moves no pointer and sets no flag.
- R7: `irq_flag` is set by the accepted write that brings the fill level to `stage_cfg`+1.
- R8: `irq` is 1 exactly when `irq_flag` and `irq_en` are both 1.
- R9: `irq_flag` and `ovf_flag` stay set until a 1 is pulsed on `clr_irq` or `clr_ovf` respectively.
- R10: A write and a pop in the same cycle on a full queue both take effect. `full` stays 1, no overflow is reported and the new entry joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Conversion result valid this cycle |
| wr_result | input | 12 | Conversion result |
| wr_src | input | 2 | Start-factor code |
| wr_chan | input | 5 | Converted channel number |
| rd_en | input | 1 | Bus read of the data word this cycle |
| rd_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| rd_lane | input | 2 | Byte address of the access within the word |
| rd_data | output | 32 | Head entry, packed |
| clr_fifo | input | 1 | Empty the queue |
| stage_cfg | input | $clog2(DEPTH) | Threshold N; the flag is raised at N+1 entries |
| irq_en | input | 1 | Interrupt enable |
| clr_irq | input | 1 | Clear the interrupt flag |
| clr_ovf | input | 1 | Clear the overflow flag |
| empty | output | 1 | Queue holds no entry |
| full | output | 1 | All stages hold data |
| ovf_flag | output | 1 | Sticky: a write was dropped |
| irq_flag | output | 1 | Sticky: threshold reached |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds two instances. The first uses the default depth of 16 with a 4-bit threshold. It covers every size and lane combination, and it fills the queue completely to reach the overflow and the simultaneous write-and-pop cases. The second instance uses a depth of 4, so the threshold field is only 2 bits wide. That instance shows that full, overflow and the largest threshold (N=3) follow the smaller pointer width.

// File: rtl/adcf_pkg.sv
package adcf_pkg;

    localparam int RES_W     = 12;
    localparam int SRC_W     = 2;
    localparam int CH_W      = 5;
    localparam int INVAL_BIT = 12;

    typedef struct packed {
        logic [RES_W-1:0] result;
        logic [SRC_W-1:0] src;
        logic [CH_W-1:0]  chan;
    } entry_t;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    // Place one entry in the 32-bit read word.
    function automatic logic [31:0] pack_word(entry_t e, logic inval);
        logic [31:0] w;
        w            = '0;
        w[31:20]     = e.result;
        w[INVAL_BIT] = inval;
        w[9:8]       = e.src;
        w[4:0]       = e.chan;
        return w;
    endfunction

endpackage

// File: rtl/adcf_lane_decode.sv
module adcf_lane_decode
    import adcf_pkg::*;
(
    input  logic [1:0] size,
    input  logic [1:0] lane,
    output logic       pop_sel
);

    always_comb begin
        unique case (size)
            ACC_WORD: pop_sel = 1'b1;
            ACC_HALF: pop_sel = lane[1];
            ACC_BYTE: pop_sel = (lane == 2'd3);
            default:  pop_sel = 1'b0;
        endcase
    end

endmodule

// File: rtl/adcf_store.sv
module adcf_store
    import adcf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push_req,
    input  logic             pop_req,
    input  entry_t           din,
    output entry_t           head,
    output logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] next_level,
    output logic             push_ok,
    output logic             ovf_evt
);

    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);

    entry_t           mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             pop_ok;

    always_comb begin
        pop_ok  = pop_req && (level != '0) && !clr;
        push_ok = push_req && !clr && ((level != LVL_FULL) || pop_ok);
        ovf_evt = push_req && !clr && !push_ok;
        next_level = level;
        if (push_ok) next_level = next_level + LVL_ONE;
        if (pop_ok)  next_level = next_level - LVL_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push_ok) wptr <= wptr + PTR_W'(1);
            if (pop_ok)  rptr <= rptr + PTR_W'(1);
            level <= next_level;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din;
    end

    assign head = mem[rptr];

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_FULL);                                               // R3

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (level == LVL_FULL && push_req && !pop_req && !clr)
            |=> ($stable(wptr) && level == LVL_FULL));                     // R3

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (level == '0));                                           // R4

    AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (level == '0 && pop_req && !push_req && !clr) |=> $stable(rptr)); // R6

    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (rst)
        (level == LVL_FULL && push_req && pop_req && !clr)
            |=> (level == LVL_FULL && !$stable(wptr)));                    // R10

endmodule

// File: rtl/adcf_flags.sv
module adcf_flags #(
    parameter int CFG_W = 4,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_ok,
    input  logic             ovf_evt,
    input  logic [LVL_W-1:0] next_level,
    input  logic [CFG_W-1:0] stage_cfg,
    input  logic             irq_en,
    input  logic             clr_irq,
    input  logic             clr_ovf,
    output logic             irq_flag,
    output logic             ovf_flag,
    output logic             irq
);

    logic [LVL_W-1:0] target;
    logic             hit;

    always_comb begin
        target = LVL_W'(stage_cfg) + LVL_W'(1);
        hit    = push_ok && (next_level == target);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            if (hit)          irq_flag <= 1'b1;
            else if (clr_irq) irq_flag <= 1'b0;
            if (ovf_evt)      ovf_flag <= 1'b1;
            else if (clr_ovf) ovf_flag <= 1'b0;
        end
    end

    assign irq = irq_flag & irq_en;

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !clr_irq) |=> irq_flag);                             // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !clr_ovf) |=> ovf_flag);                             // R9

    AST_OVF_RECORD: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> ovf_flag);                                            // R3

    AST_IRQ_RECORD: assert property (@(posedge clk) disable iff (rst)
        hit |=> irq_flag);                                                // R7

endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo
    import adcf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CFG_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [11:0]      wr_result,
    input  logic [1:0]       wr_src,
    input  logic [4:0]       wr_chan,
    input  logic             rd_en,
    input  logic [1:0]       rd_size,
    input  logic [1:0]       rd_lane,
    output logic [31:0]      rd_data,
    input  logic             clr_fifo,
    input  logic [CFG_W-1:0] stage_cfg,
    input  logic             irq_en,
    input  logic             clr_irq,
    input  logic             clr_ovf,
    output logic             empty,
    output logic             full,
    output logic             ovf_flag,
    output logic             irq_flag,
    output logic             irq
);

    localparam int LVL_W = $clog2(DEPTH + 1);

    entry_t           din, head;
    logic [LVL_W-1:0] level, next_level;
    logic             pop_sel, push_ok, ovf_evt;

    assign din = '{result: wr_result, src: wr_src, chan: wr_chan};

    adcf_lane_decode u_lane (
        .size    (rd_size),
        .lane    (rd_lane),
        .pop_sel (pop_sel)
    );

    adcf_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr_fifo),
        .push_req   (wr_en),
        .pop_req    (rd_en & pop_sel),
        .din        (din),
        .head       (head),
        .level      (level),
        .next_level (next_level),
        .push_ok    (push_ok),
        .ovf_evt    (ovf_evt)
    );

    adcf_flags #(.CFG_W(CFG_W), .LVL_W(LVL_W)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .push_ok    (push_ok),
        .ovf_evt    (ovf_evt),
        .next_level (next_level),
        .stage_cfg  (stage_cfg),
        .irq_en     (irq_en),
        .clr_irq    (clr_irq),
        .clr_ovf    (clr_ovf),
        .irq_flag   (irq_flag),
        .ovf_flag   (ovf_flag),
        .irq        (irq)
    );

    assign empty   = (level == '0);
    assign full    = (level == LVL_W'(DEPTH));
    assign rd_data = empty ? pack_word('0, 1'b1) : pack_word(head, 1'b0);

    AST_NO_FLAG_ON_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en && !ovf_flag) |=> !ovf_flag);            // R6

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (empty && !irq_flag && !ovf_flag));                       // R1

endmodule

// File: tb/sim_adc_result_fifo.sv
module sim_adc_result_fifo;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 0, rd_en = 0, clr_fifo = 0, irq_en = 0, clr_irq = 0, clr_ovf = 0;
    logic [11:0] wr_result = '0;
    logic [1:0]  wr_src = '0, rd_size = '0, rd_lane = '0;
    logic [4:0]  wr_chan = '0;
    logic [3:0]  stage_cfg = '0;
    logic [31:0] rd_data;
    logic        empty, full, ovf_flag, irq_flag, irq;

    logic        p_wr = 0, p_rd = 0;
    logic [1:0]  p_cfg = '0;
    logic [31:0] p_data;
    logic        p_empty, p_full, p_ovf, p_iflag, p_irq;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    adc_result_fifo #(.DEPTH(16)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_result(wr_result), .wr_src(wr_src),
        .wr_chan(wr_chan), .rd_en(rd_en), .rd_size(rd_size), .rd_lane(rd_lane),
        .rd_data(rd_data), .clr_fifo(clr_fifo), .stage_cfg(stage_cfg), .irq_en(irq_en),
        .clr_irq(clr_irq), .clr_ovf(clr_ovf), .empty(empty), .full(full),
        .ovf_flag(ovf_flag), .irq_flag(irq_flag), .irq(irq)
    );

    adc_result_fifo #(.DEPTH(4)) u1 (
        .clk(clk), .rst(rst), .wr_en(p_wr), .wr_result(12'hA5A), .wr_src(2'd1),
        .wr_chan(5'd7), .rd_en(p_rd), .rd_size(2'd2), .rd_lane(2'd0),
        .rd_data(p_data), .clr_fifo(1'b0), .stage_cfg(p_cfg), .irq_en(1'b1),
        .clr_irq(1'b0), .clr_ovf(1'b0), .empty(p_empty), .full(p_full),
        .ovf_flag(p_ovf), .irq_flag(p_iflag), .irq(p_irq)
    );

    // {size[1:0], lane[1:0], expected pop}
    localparam logic [4:0] VEC [8] = '{
        {2'd2, 2'd0, 1'b1}, {2'd2, 2'd3, 1'b1},
        {2'd1, 2'd0, 1'b0}, {2'd1, 2'd2, 1'b1},
        {2'd0, 2'd0, 1'b0}, {2'd0, 2'd1, 1'b0},
        {2'd0, 2'd2, 1'b0}, {2'd0, 2'd3, 1'b1}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] ew(input int i);
        logic [31:0] w;
        w        = '0;
        w[31:20] = 12'(12'h100 + i);
        w[9:8]   = 2'(i);
        w[4:0]   = 5'(i);
        return w;
    endfunction

    task automatic step(input logic we, input int i, input logic re, input logic [1:0] sz,
                        input logic [1:0] ln, input logic cf, input logic ci, input logic co);
        @(negedge clk);
        wr_en = we; wr_result = 12'(12'h100 + i); wr_src = 2'(i); wr_chan = 5'(i);
        rd_en = re; rd_size = sz; rd_lane = ln;
        clr_fifo = cf; clr_irq = ci; clr_ovf = co;
        @(posedge clk); #1;
        wr_en = 0; rd_en = 0; clr_fifo = 0; clr_irq = 0; clr_ovf = 0;
    endtask

    task automatic push(input int i);  step(1, i, 0, 2'd2, 2'd0, 0, 0, 0); endtask
    task automatic popw();             step(0, 0, 1, 2'd2, 2'd0, 0, 0, 0); endtask
    task automatic clear_all();        step(0, 0, 0, 2'd2, 2'd0, 1, 1, 1); endtask

    task automatic pstep(input logic we, input logic re);
        @(negedge clk); p_wr = we; p_rd = re;
        @(posedge clk); #1; p_wr = 0; p_rd = 0;
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 / R6: reset state
        chk(empty, 1, "R1 empty after reset");
        chk({full, ovf_flag, irq_flag, irq}, 0, "R1 flags after reset");
        chk(rd_data, 32'h0000_1000, "R6 invalid word when empty");

        // R5: pop decode table
        for (int v = 0; v < 8; v++) begin
            push(v);
            step(0, 0, 1, VEC[v][4:3], VEC[v][2:1], 0, 0, 0);
            chk(empty, VEC[v][0], $sformatf("R5 size=%0d lane=%0d pop", VEC[v][4:3], VEC[v][2:1]));
            clear_all();
            chk(empty, 1, "R4 clear empties");
        end

        // R2: order and field layout
        push(3); push(9); push(22);
        chk(rd_data, ew(3), "R2 head first entry");
        popw();
        chk(rd_data, ew(9), "R2 second entry");
        popw();
        chk(rd_data, ew(22), "R2 third entry");
        popw();
        chk(empty, 1, "R2 drained");

        // R6: read on empty leaves pointers and flags alone
        popw(); popw();
        chk({empty, ovf_flag}, 2'b10, "R6 empty read no flag");
        push(5);
        chk(rd_data, ew(5), "R6 pointers unchanged after empty read");
        clear_all();

        // R3: full and overflow
        for (int i = 0; i < 15; i++) push(i);
        chk(full, 0, "R3 not full at DEPTH-1");
        push(15);
        chk(full, 1, "R3 full at DEPTH");
        chk(ovf_flag, 0, "R3 no overflow yet");
        push(30);
        chk(ovf_flag, 1, "R3 overflow set");
        chk(rd_data, ew(0), "R3 head intact after drop");
        for (int i = 0; i < 15; i++) popw();
        chk(rd_data, ew(15), "R3 last kept entry");
        popw();
        chk(empty, 1, "R3 dropped entry absent");

        // R9: overflow sticky then cleared
        repeat (3) step(0, 0, 0, 2'd2, 2'd0, 0, 0, 0);
        chk(ovf_flag, 1, "R9 overflow sticky");
        step(0, 0, 0, 2'd2, 2'd0, 0, 0, 1);
        chk(ovf_flag, 0, "R9 overflow cleared");

        // R7 / R8 / R9: threshold interrupt
        clear_all();
        stage_cfg = 4'd2;
        irq_en = 0;
        push(1); push(2);
        chk(irq_flag, 0, "R7 below threshold");
        push(3);
        chk(irq_flag, 1, "R7 flag at N+1");
        chk(irq, 0, "R8 masked when disabled");
        irq_en = 1; #1;
        chk(irq, 1, "R8 request when enabled");
        push(4);
        chk(irq_flag, 1, "R9 flag sticky");
        step(0, 0, 0, 2'd2, 2'd0, 0, 1, 0);
        chk({irq_flag, irq}, 2'b00, "R9 flag cleared");

        // R10: write and pop together on full
        clear_all();
        irq_en = 0;
        for (int i = 0; i < 16; i++) push(i);
        step(1, 20, 1, 2'd2, 2'd0, 0, 0, 0);
        chk({full, ovf_flag}, 2'b10, "R10 full kept, no overflow");
        chk(rd_data, ew(1), "R10 head advanced");
        for (int i = 0; i < 15; i++) popw();
        chk(rd_data, ew(20), "R10 new entry at tail");

        // Depth-4 instance: 2-bit threshold, full, overflow
        p_cfg = 2'd3;
        pstep(1, 0); pstep(1, 0); pstep(1, 0);
        chk({p_full, p_iflag}, 2'b00, "R7 depth4 below threshold");
        pstep(1, 0);
        chk({p_full, p_iflag, p_irq}, 3'b111, "R7 depth4 N=3 and full");
        pstep(1, 0);
        chk(p_ovf, 1, "R3 depth4 overflow");
        chk(p_data, 32'hA5A0_0107, "R2 depth4 word layout");

        finish_up();
    end

endmodule